// File: doc/BRIEF.md
# Core-Local Interrupt Router

This block gathers the interrupt sources that belong to each processor core and turns them into one interrupt request per core. Each core has four generic-timer lines, and each line can be enabled separately in that core's own timer-enable register. Two shared fast lines are also routed. The GPU line goes to a single core chosen by a small route register. The PMU line goes to any set of cores, and that set is kept in a routing mask that changes only through separate set and clear addresses. A mailbox summary line per core is passed through without a mask.

The enabled sources of a core form its pending word, which software can read. The word is ordered so that servicing the lowest set bit first handles the timers before the mailbox, the GPU line and the PMU line. A core's interrupt output is high whenever any bit of its pending word is high. Configuration and status go over a simple single-cycle register bus, and read data comes back one cycle after the request.

Top module: `lirq_router`

## Requirements
- R1: After reset, every timer-enable register, the PMU routing mask and the GPU route all read zero, and with all sources low every `irq` bit is 0.
- R2: A write to address 0x00 + 4*n stores bits [3:0] of the write data as the timer enables of core n. Bit t enables timer line t of that core (0 physical secure, 1 physical non-secure, 2 hypervisor, 3 virtual). Upper data bits are dropped and reading the address back returns the stored enables.
- R3: A write to 0x10 sets PMU routing for every core n whose data bit n is 1. Bits that are 0 leave routing unchanged, and the mask changes only on writes to 0x10 or 0x14.
- R4: A write to 0x14 clears PMU routing for every core n whose data bit n is 1. Bits that are 0 leave routing unchanged.
- R5: A read of 0x10 or 0x14 returns the current PMU routing mask in bits [3:0].
- R6: A write to 0x18 stores bits [1:0] as the core index that receives the GPU line. Reading the address returns that index.
- R7: A read of 0x20 + 4*n returns the pending word of core n. Bits [3:0] hold timer line t AND enable t. Bit 4 holds the mailbox summary of core n. Bit 5 holds the GPU line when the GPU route equals n. Bit 6 holds the PMU line when routing bit n is set. Every other bit is 0.
- R8: `irq[n]` is the OR of the pending bits of core n, follows source changes in the same cycle, and reflects a new enable from the clock edge that stores it.
- R9: Read data appears on `busRdata` on the clock edge after a read request and holds until the next read. A read of any other address returns 0. Writes to pending or unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus request this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| timerIrq | input | 16 | Timer lines, bit 4*n+t is timer t of core n |
| gpuIrq | input | 1 | Shared fast GPU line |
| pmuIrq | input | 1 | Shared fast PMU line |
| mbxIrq | input | 4 | Mailbox summary per core |
| irq | output | 4 | Interrupt request per core |

## Verification
The case that needs care is a bus write that changes an enable, the PMU mask or the GPU route in the same cycle that the matching source line changes. The bench raises a timer line in the same cycle that it writes the enable for that line. During that cycle `irq` must still reflect the old enable, and it must reflect the new one after the edge. A behavioural model that updates its state only at clock edges judges both, and it also judges many random writes that are mixed with source toggles.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int CORE_W       = 2;
  localparam int TIMER_BASE   = 'h00;
  localparam int PMU_SET_OFF  = 'h10;
  localparam int PMU_CLR_OFF  = 'h14;
  localparam int GPU_ROUTE_OFF = 'h18;
  localparam int PEND_BASE    = 'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TIMER,
    SEL_PMU_SET,
    SEL_PMU_CLR,
    SEL_GPU,
    SEL_PEND
  } regSel_e;

  typedef struct packed {
    logic              wr;
    logic              rd;
    regSel_e           sel;
    logic [CORE_W-1:0] core;
  } busStrobe_t;
endpackage

// File: rtl/lirq_ctrl.sv
module lirq_ctrl
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        stb
);
  localparam int TIMER_END = TIMER_BASE + 4 * NUM_CORES;
  localparam int PEND_END  = PEND_BASE + 4 * NUM_CORES;

  always_comb begin
    stb.wr   = busSel && busWr;
    stb.rd   = busSel && !busWr;
    stb.core = busAddr[CORE_W+1:2];
    stb.sel  = SEL_NONE;
    if (busSel && busAddr[1:0] == 2'b00) begin
      if (busAddr < ADDR_W'(TIMER_END))
        stb.sel = SEL_TIMER;
      else if (busAddr == ADDR_W'(PMU_SET_OFF))
        stb.sel = SEL_PMU_SET;
      else if (busAddr == ADDR_W'(PMU_CLR_OFF))
        stb.sel = SEL_PMU_CLR;
      else if (busAddr == ADDR_W'(GPU_ROUTE_OFF))
        stb.sel = SEL_GPU;
      else if (busAddr >= ADDR_W'(PEND_BASE) && busAddr < ADDR_W'(PEND_END))
        stb.sel = SEL_PEND;
    end
  end
endmodule

// File: rtl/lirq_datapath.sv
module lirq_datapath
  import lirq_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int NUM_TIMERS = 4,
  parameter int DATA_W     = 32,
  localparam int PEND_W    = NUM_TIMERS + 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  busStrobe_t                    stb,
  input  logic [DATA_W-1:0]             busWdata,
  input  logic [NUM_CORES*NUM_TIMERS-1:0] timerIrq,
  input  logic                          gpuIrq,
  input  logic                          pmuIrq,
  input  logic [NUM_CORES-1:0]          mbxIrq,
  output logic [NUM_CORES*PEND_W-1:0]   pendFlat,
  output logic [NUM_CORES*NUM_TIMERS-1:0] timerEnFlat,
  output logic [NUM_CORES-1:0]          pmuMask,
  output logic [CORE_W-1:0]             gpuRoute,
  output logic [DATA_W-1:0]             busRdata
);
  logic [NUM_TIMERS-1:0] timerEn [NUM_CORES];
  logic [DATA_W-1:0]     rdNext;

  // enable and routing storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CORES; c++) timerEn[c] <= '0;
      pmuMask  <= '0;
      gpuRoute <= '0;
    end else if (stb.wr) begin
      case (stb.sel)
        SEL_TIMER:   timerEn[stb.core] <= busWdata[NUM_TIMERS-1:0];
        SEL_PMU_SET: pmuMask <= pmuMask | busWdata[NUM_CORES-1:0];
        SEL_PMU_CLR: pmuMask <= pmuMask & ~busWdata[NUM_CORES-1:0];
        SEL_GPU:     gpuRoute <= busWdata[CORE_W-1:0];
        default:     ;
      endcase
    end
  end

  // per-core pending word: timers low, then mailbox, GPU, PMU
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign timerEnFlat[c*NUM_TIMERS +: NUM_TIMERS] = timerEn[c];
    assign pendFlat[c*PEND_W +: PEND_W] = {
      pmuIrq & pmuMask[c],
      gpuIrq & (gpuRoute == CORE_W'(c)),
      mbxIrq[c],
      timerIrq[c*NUM_TIMERS +: NUM_TIMERS] & timerEn[c]
    };
  end

  always_comb begin
    case (stb.sel)
      SEL_TIMER:   rdNext = DATA_W'(timerEn[stb.core]);
      SEL_PMU_SET,
      SEL_PMU_CLR: rdNext = DATA_W'(pmuMask);
      SEL_GPU:     rdNext = DATA_W'(gpuRoute);
      SEL_PEND:    rdNext = DATA_W'(pendFlat[stb.core*PEND_W +: PEND_W]);
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)       busRdata <= '0;
    else if (stb.rd) busRdata <= rdNext;
  end
endmodule

// File: rtl/lirq_router.sv
module lirq_router
  import lirq_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int NUM_TIMERS = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busSel,
  input  logic                            busWr,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [DATA_W-1:0]               busWdata,
  output logic [DATA_W-1:0]               busRdata,
  input  logic [NUM_CORES*NUM_TIMERS-1:0] timerIrq,
  input  logic                            gpuIrq,
  input  logic                            pmuIrq,
  input  logic [NUM_CORES-1:0]            mbxIrq,
  output logic [NUM_CORES-1:0]            irq
);
  localparam int PEND_W = NUM_TIMERS + 3;

  busStrobe_t                      stb;
  logic [NUM_CORES*PEND_W-1:0]     pendFlat;
  logic [NUM_CORES*NUM_TIMERS-1:0] timerEnFlat;
  logic [NUM_CORES-1:0]            pmuMask;
  logic [CORE_W-1:0]               gpuRoute;

  lirq_ctrl #(
    .NUM_CORES(NUM_CORES),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .stb    (stb)
  );

  lirq_datapath #(
    .NUM_CORES (NUM_CORES),
    .NUM_TIMERS(NUM_TIMERS),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .busWdata   (busWdata),
    .timerIrq   (timerIrq),
    .gpuIrq     (gpuIrq),
    .pmuIrq     (pmuIrq),
    .mbxIrq     (mbxIrq),
    .pendFlat   (pendFlat),
    .timerEnFlat(timerEnFlat),
    .pmuMask    (pmuMask),
    .gpuRoute   (gpuRoute),
    .busRdata   (busRdata)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_irq
    assign irq[c] = |pendFlat[c*PEND_W +: PEND_W];
  end
endmodule

// File: rtl/lirq_checker.sv
module lirq_checker
  import lirq_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int NUM_TIMERS = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            busSel,
  input logic                            busWr,
  input logic [ADDR_W-1:0]               busAddr,
  input logic [DATA_W-1:0]               busWdata,
  input logic [DATA_W-1:0]               busRdata,
  input logic [NUM_CORES*NUM_TIMERS-1:0] timerIrq,
  input logic                            gpuIrq,
  input logic                            pmuIrq,
  input logic [NUM_CORES-1:0]            mbxIrq,
  input logic [NUM_CORES-1:0]            irq,
  input logic [NUM_CORES-1:0]            pmuMask,
  input logic [NUM_CORES*NUM_TIMERS-1:0] timerEnFlat
);
  logic pmuWrite;
  assign pmuWrite = busSel && busWr &&
                    (busAddr == ADDR_W'(PMU_SET_OFF) || busAddr == ADDR_W'(PMU_CLR_OFF));

  AST_TIMER0_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == '0) |=>
      timerEnFlat[NUM_TIMERS-1:0] == $past(busWdata[NUM_TIMERS-1:0])); // R2

  AST_PMU_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pmuWrite |=> $stable(pmuMask)); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr >= ADDR_W'('h40)) |=> busRdata == '0); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWr) |=> $stable(busRdata)); // R9

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    AST_PMU_SET_BIT: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && busWr && busAddr == ADDR_W'(PMU_SET_OFF) && busWdata[c]) |=> pmuMask[c]); // R3

    AST_PMU_CLR_BIT: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && busWr && busAddr == ADDR_W'(PMU_CLR_OFF) && busWdata[c]) |=> !pmuMask[c]); // R4

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
      irq[c] |-> (mbxIrq[c] || gpuIrq || pmuIrq ||
                  (|timerIrq[c*NUM_TIMERS +: NUM_TIMERS]))); // R8

    AST_MBX_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
      mbxIrq[c] |-> irq[c]); // R8
  end
endmodule

bind lirq_router lirq_checker #(
  .NUM_CORES (NUM_CORES),
  .NUM_TIMERS(NUM_TIMERS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (.*);

// File: tb/tb_lirq_router.sv
module tb_lirq_router;
  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel;
  logic        busWr;
  logic [7:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic [15:0] timerIrq;
  logic        gpuIrq;
  logic        pmuIrq;
  logic [3:0]  mbxIrq;
  logic [3:0]  irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lirq_router dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .timerIrq(timerIrq), .gpuIrq(gpuIrq), .pmuIrq(pmuIrq),
    .mbxIrq(mbxIrq), .irq(irq)
  );

  // behavioural reference state
  logic [3:0]  mEn [4];
  logic [3:0]  mPmu;
  logic [1:0]  mGpu;
  logic [31:0] mRd;

  function automatic logic [31:0] modelPend(int c);
    logic [31:0] w;
    w = 32'(timerIrq[c*4 +: 4] & mEn[c]);
    if (mbxIrq[c])            w = w | 32'h10;
    if (gpuIrq && mGpu == c)  w = w | 32'h20;
    if (pmuIrq && mPmu[c])    w = w | 32'h40;
    return w;
  endfunction

  function automatic logic [31:0] modelRead(int a);
    if (a % 4 != 0)           return 0;
    if (a < 16)               return 32'(mEn[a/4]);
    if (a == 16 || a == 20)   return 32'(mPmu);
    if (a == 24)              return 32'(mGpu);
    if (a >= 32 && a < 48)    return modelPend((a - 32) / 4);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 4; c++) mEn[c] <= 4'h0;
      mPmu <= 4'h0;
      mGpu <= 2'd0;
      mRd  <= 32'h0;
    end else if (busSel) begin
      if (!busWr) mRd <= modelRead(int'(busAddr));
      else if (busAddr < 16 && busAddr[1:0] == 2'b00) mEn[busAddr[3:2]] <= busWdata[3:0];
      else if (busAddr == 8'h10) mPmu <= mPmu | busWdata[3:0];
      else if (busAddr == 8'h14) mPmu <= mPmu & ~busWdata[3:0];
      else if (busAddr == 8'h18) mGpu <= busWdata[1:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] modelIrq();
    logic [3:0] v;
    for (int c = 0; c < 4; c++) v[c] = |modelPend(c);
    return v;
  endfunction

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R8 irq vs model", 32'(irq), 32'(modelIrq()));
      chk("R9 rdata vs model", busRdata, mRd);
    end
  end

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    step();
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    step();
    busSel = 1'b0;
    chk(tag, busRdata, exp);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #4_000_000;
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; busAddr = '0; busWdata = '0;
    timerIrq = '0; gpuIrq = 1'b0; pmuIrq = 1'b0; mbxIrq = '0;
    step(); step();
    rstN = 1'b1;
    step();

    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 32'h0);
    busRead(8'h00, 32'h0, "R1 timer enable core0");
    busRead(8'h10, 32'h0, "R1 pmu mask");
    busRead(8'h18, 32'h0, "R1 gpu route");

    // R2 timer enables, upper bits dropped
    busWrite(8'h04, 32'hFFFF_FFF5);
    busRead(8'h04, 32'h5, "R2 core1 enables");
    busRead(8'h00, 32'h0, "R2 core0 untouched");

    // R3 R4 R5 PMU routing
    busWrite(8'h10, 32'h5);
    busRead(8'h10, 32'h5, "R3 set 0101");
    busWrite(8'h10, 32'h2);
    busRead(8'h10, 32'h7, "R3 set keeps other bits");
    busWrite(8'h14, 32'h4);
    busRead(8'h14, 32'h3, "R4 clear bit2, R5 read via clear addr");
    busRead(8'h10, 32'h3, "R5 read via set addr");

    // R6 GPU route
    busWrite(8'h18, 32'hFFFF_FFFE);
    busRead(8'h18, 32'h2, "R6 gpu route to core2");

    // R7 pending words with all sources active
    timerIrq = 16'hFFFF; gpuIrq = 1'b1; pmuIrq = 1'b1; mbxIrq = 4'b1000;
    busRead(8'h20, 32'h40, "R7 pending core0");
    busRead(8'h24, 32'h45, "R7 pending core1");
    busRead(8'h28, 32'h20, "R7 pending core2");
    busRead(8'h2C, 32'h10, "R7 pending core3");
    chk("R8 all cores requesting", 32'(irq), 32'hF);

    // R9 unmapped and read-only targets
    busRead(8'h40, 32'h0, "R9 unmapped read");
    busRead(8'h05, 32'h0, "R9 misaligned read");
    busWrite(8'h24, 32'h0);
    busWrite(8'h3C, 32'hFFFF_FFFF);
    busRead(8'h04, 32'h5, "R9 write to pending ignored");
    busRead(8'h24, 32'h45, "R9 pending unchanged");

    // R8 enable write and source rise in the same cycle
    timerIrq = '0; gpuIrq = 1'b0; pmuIrq = 1'b0; mbxIrq = '0;
    step();
    chk("R8 quiet", 32'(irq), 32'h0);
    busSel = 1'b1; busWr = 1'b1; busAddr = 8'h00; busWdata = 32'h1;
    timerIrq[0] = 1'b1;
    @(negedge clk);
    chk("R8 old enable before edge", 32'(irq[0]), 32'h0);
    @(posedge clk); #5;
    busSel = 1'b0; busWr = 1'b0;
    chk("R8 new enable after edge", 32'(irq[0]), 32'h1);
    timerIrq[0] = 1'b0;
    #1;
    chk("R8 source fall same cycle", 32'(irq[0]), 32'h0);

    // random mix judged by the model every cycle
    for (int i = 0; i < 600; i++) begin
      int kind;
      logic [7:0] addrs [10];
      addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h24, 8'h2C, 8'h50};
      kind = int'($urandom_range(0, 3));
      timerIrq = 16'($urandom);
      gpuIrq   = 1'($urandom);
      pmuIrq   = 1'($urandom);
      mbxIrq   = 4'($urandom);
      busSel   = (kind != 0);
      busWr    = (kind == 1 || kind == 2);
      busAddr  = addrs[$urandom_range(0, 9)];
      busWdata = $urandom;
      step();
    end
    busSel = 1'b0;
    step();
    finishRun();
  end
endmodule